// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block turns edges on general-purpose input pins into interrupt requests. Up to six 16-pin input ports arrive on one flat bus. Sixteen interrupt lines each watch one pin, and line N can only take pin N of some port. Software picks that port through a 3-bit selection code. It also enables rising and/or falling detection per line and unmasks the lines it wants to hear from.

Every detected edge sets a sticky flag in a rising-pending or falling-pending register. Software clears a flag by writing 1 to it. Unmasked flags are ORed into three shared request outputs: one for lines 0–1, one for lines 2–3 and one for lines 4–15. An interrupt handler reads the pending registers to find out which line fired.

Each line runs a two-flop synchronizer, a previous-value register and a small state machine. The machine has two states. In LN_SETTLE edge reporting is off while the synchronizer refills. In LN_WATCH edges are reported. The transitions are:
- reset enters LN_SETTLE;
- LN_SETTLE moves to LN_WATCH after three cycles;
- any change of the line's port selection sends the line from either state back to LN_SETTLE with its cycle count cleared.

Top module: `pin_edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and all three request outputs are 0.
- R2: Register addresses 0 to 3 hold the port selection. Line N sits at address N/4, bits [8*(N%4)+2 : 8*(N%4)]. Codes 0 to 5 pick ports A to F. Port p pin n is `gpio_in[16*p+n]`. The five upper bits of each 8-bit field read back as 0.
- R3: Selection codes 6 and 7 connect no pin. On lines 14 and 15, code 5 (port F) also connects no pin. Edges then set no flag.
- R4: A rising edge on the selected pin of a line whose bit is set in the rise-enable register (address 4) sets that line's bit in the rising-pending register (address 7). The bit is readable after the third rising clock edge that follows the pin change, and not before.
- R5: A falling edge on a line enabled in the fall-enable register (address 5) sets its bit in the falling-pending register (address 8). A line with both enables reacts to both edges. An edge whose direction is not enabled sets nothing.
- R6: Pins of ports other than the selected one have no effect on a line.
- R7: Pending bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: If an edge sets a pending bit in the same cycle that software writes 1 to clear it, the bit ends up set.
- R9: `irq_req[0]`, `irq_req[1]` and `irq_req[2]` are the OR of (rising or falling pending) AND mask over lines 0–1, 2–3 and 4–15, where the mask is at address 6. A masked line still records its pending bits.
- R10: Changing a line's selection code never creates an edge, even when the old and new pins differ in level. Edge detection resumes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | 96 | Raw pins, port p pin n at bit 16*p+n |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| irq_req | output | 3 | Grouped interrupt requests (lines 0–1, 2–3, 4–15) |

## Verification
Two functions can hit the same pending bit in one cycle: a freshly detected edge setting it and a software write clearing it. The bench provokes this on line 4. It first sets the rising flag. It then produces a new rising edge and places a write-1 to that bit on exactly the clock edge where the synchronizer delivers the new level. The rule is that the bit must read 1 afterwards, and a second clear with no edge must then empty it. A second collision is a selection change while the old and new pins differ. Its outcome is judged by both pending registers staying 0 and by a later real edge still being caught.

// File: rtl/pin_edge_irq_pkg.sv
package pin_edge_irq_pkg;

    localparam int RF_ADDR_W = 4;

    typedef enum logic [RF_ADDR_W-1:0] {
        RA_SEL0      = 4'd0,
        RA_SEL1      = 4'd1,
        RA_SEL2      = 4'd2,
        RA_SEL3      = 4'd3,
        RA_RISE_EN   = 4'd4,
        RA_FALL_EN   = 4'd5,
        RA_MASK      = 4'd6,
        RA_RISE_PEND = 4'd7,
        RA_FALL_PEND = 4'd8
    } rf_addr_e;

    typedef enum logic {
        LN_SETTLE = 1'b0,
        LN_WATCH  = 1'b1
    } ln_state_e;

    // Number of ports a line may legally select.
    function automatic int line_port_count(input int line, input int num_ports, input int short_from);
        return (line >= short_from) ? num_ports - 1 : num_ports;
    endfunction

endpackage

// File: rtl/pei_line_watch.sv
module pei_line_watch
    import pin_edge_irq_pkg::*;
#(
    parameter int NUM_PORTS   = 6,
    parameter int SEL_W       = 3,
    parameter int AVAIL_PORTS = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_pins,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 resel,
    output logic                 rise_det,
    output logic                 fall_det
);
    localparam int SETTLE_LEN = SYNC_STAGES + 1;
    localparam int CNT_W      = $clog2(SETTLE_LEN + 1);

    logic                   raw_pin;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   cur_lvl;
    logic                   prev_q;
    ln_state_e              state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;

    // Port selection; unavailable codes connect nothing.
    always_comb begin
        raw_pin = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (p < AVAIL_PORTS && sel == SEL_W'(p)) begin
                raw_pin = port_pins[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign cur_lvl = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_SETTLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LN_SETTLE: begin
                if (cnt_q == CNT_W'(SETTLE_LEN - 1)) begin
                    state_d = LN_WATCH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            LN_WATCH: begin
                cnt_d = '0;
            end
            default: begin
                state_d = LN_SETTLE;
                cnt_d   = '0;
            end
        endcase
        if (resel) begin
            state_d = LN_SETTLE;
            cnt_d   = '0;
        end
    end

    // Outputs
    always_comb begin
        rise_det = 1'b0;
        fall_det = 1'b0;
        unique case (state_q)
            LN_WATCH: begin
                rise_det = cur_lvl & ~prev_q;
                fall_det = ~cur_lvl & prev_q;
            end
            default: begin
                rise_det = 1'b0;
                fall_det = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pei_regfile.sv
module pei_regfile
    import pin_edge_irq_pkg::*;
#(
    parameter int LINES   = 16,
    parameter int SEL_W   = 3,
    parameter int FIELD_W = 8,
    parameter int DATA_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [RF_ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [LINES-1:0]       rise_det,
    input  logic [LINES-1:0]       fall_det,
    output logic [LINES*SEL_W-1:0] sel_flat,
    output logic [LINES-1:0]       resel,
    output logic [LINES-1:0]       mask_q,
    output logic [LINES-1:0]       rpend_q,
    output logic [LINES-1:0]       fpend_q,
    output logic [LINES-1:0]       rise_set,
    output logic [LINES-1:0]       fall_set
);
    localparam int LPR  = DATA_W / FIELD_W;
    localparam int NSEL = LINES / LPR;

    logic [SEL_W-1:0] sel_q [LINES];
    logic [LINES-1:0] rise_en_q, fall_en_q;
    logic [LINES-1:0] rclr, fclr;
    logic             unused_ok;

    assign unused_ok = ^bus_wdata;

    for (genvar l = 0; l < LINES; l++) begin : g_sel
        localparam int RI = l / LPR;
        localparam int FB = (l % LPR) * FIELD_W;
        logic             hit;
        logic [SEL_W-1:0] new_sel;

        assign hit      = bus_wr && (bus_addr == RF_ADDR_W'(RI));
        assign new_sel  = bus_wdata[FB +: SEL_W];
        assign resel[l] = hit && (new_sel != sel_q[l]);
        assign sel_flat[l*SEL_W +: SEL_W] = sel_q[l];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sel_q[l] <= '0;
            else if (hit) sel_q[l] <= new_sel;
        end
    end

    assign rise_set = rise_det & rise_en_q;
    assign fall_set = fall_det & fall_en_q;
    assign rclr = (bus_wr && bus_addr == RA_RISE_PEND) ? bus_wdata[LINES-1:0] : '0;
    assign fclr = (bus_wr && bus_addr == RA_FALL_PEND) ? bus_wdata[LINES-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
            mask_q    <= '0;
            rpend_q   <= '0;
            fpend_q   <= '0;
        end else begin
            if (bus_wr && bus_addr == RA_RISE_EN) rise_en_q <= bus_wdata[LINES-1:0];
            if (bus_wr && bus_addr == RA_FALL_EN) fall_en_q <= bus_wdata[LINES-1:0];
            if (bus_wr && bus_addr == RA_MASK)    mask_q    <= bus_wdata[LINES-1:0];
            // A new edge outranks a same-cycle clear.
            rpend_q <= (rpend_q & ~rclr) | rise_set;
            fpend_q <= (fpend_q & ~fclr) | fall_set;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < RF_ADDR_W'(NSEL)) begin
            for (int l = 0; l < LINES; l++) begin
                if (bus_addr == RF_ADDR_W'(l / LPR)) begin
                    bus_rdata[(l % LPR)*FIELD_W +: SEL_W] = sel_q[l];
                end
            end
        end else begin
            case (rf_addr_e'(bus_addr))
                RA_RISE_EN:   bus_rdata[LINES-1:0] = rise_en_q;
                RA_FALL_EN:   bus_rdata[LINES-1:0] = fall_en_q;
                RA_MASK:      bus_rdata[LINES-1:0] = mask_q;
                RA_RISE_PEND: bus_rdata[LINES-1:0] = rpend_q;
                RA_FALL_PEND: bus_rdata[LINES-1:0] = fpend_q;
                default:      bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pei_irq_merge.sv
module pei_irq_merge #(
    parameter int LINES = 16,
    parameter int G0_HI = 1,
    parameter int G1_HI = 3
) (
    input  logic [LINES-1:0] rpend,
    input  logic [LINES-1:0] fpend,
    input  logic [LINES-1:0] mask,
    output logic [2:0]       irq_req
);
    logic [LINES-1:0] active;

    assign active     = (rpend | fpend) & mask;
    assign irq_req[0] = |active[G0_HI:0];
    assign irq_req[1] = |active[G1_HI:G0_HI+1];
    assign irq_req[2] = |active[LINES-1:G1_HI+1];

endmodule

// File: rtl/pin_edge_irq_ctrl.sv
module pin_edge_irq_ctrl
    import pin_edge_irq_pkg::*;
#(
    parameter int NUM_PORTS   = 6,
    parameter int PORT_W      = 16,
    parameter int SEL_W       = 3,
    parameter int FIELD_W     = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int SHORT_FROM  = 14,
    parameter int G0_HI       = 1,
    parameter int G1_HI       = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0] gpio_in,
    input  logic                        bus_wr,
    input  logic [RF_ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic [2:0]                  irq_req
);
    localparam int LINES = PORT_W;

    logic [LINES*SEL_W-1:0] sel_flat;
    logic [LINES-1:0]       resel, mask_q, rpend_q, fpend_q;
    logic [LINES-1:0]       rise_det, fall_det, rise_set, fall_set;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [NUM_PORTS-1:0] pins;
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pin
            assign pins[p] = gpio_in[p*PORT_W + l];
        end
        pei_line_watch #(
            .NUM_PORTS  (NUM_PORTS),
            .SEL_W      (SEL_W),
            .AVAIL_PORTS(line_port_count(l, NUM_PORTS, SHORT_FROM)),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_watch (
            .clk      (clk),
            .rst_n    (rst_n),
            .port_pins(pins),
            .sel      (sel_flat[l*SEL_W +: SEL_W]),
            .resel    (resel[l]),
            .rise_det (rise_det[l]),
            .fall_det (fall_det[l])
        );
    end

    pei_regfile #(
        .LINES  (LINES),
        .SEL_W  (SEL_W),
        .FIELD_W(FIELD_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .rise_det (rise_det),
        .fall_det (fall_det),
        .sel_flat (sel_flat),
        .resel    (resel),
        .mask_q   (mask_q),
        .rpend_q  (rpend_q),
        .fpend_q  (fpend_q),
        .rise_set (rise_set),
        .fall_set (fall_set)
    );

    pei_irq_merge #(
        .LINES(LINES),
        .G0_HI(G0_HI),
        .G1_HI(G1_HI)
    ) u_merge (
        .rpend  (rpend_q),
        .fpend  (fpend_q),
        .mask   (mask_q),
        .irq_req(irq_req)
    );

endmodule

// File: rtl/pin_edge_irq_ctrl_chk.sv
module pin_edge_irq_ctrl_chk #(
    parameter int LINES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [2:0]       irq_req,
    input logic [LINES-1:0] rise_det,
    input logic [LINES-1:0] fall_det,
    input logic [LINES-1:0] rise_set,
    input logic [LINES-1:0] fall_set,
    input logic [LINES-1:0] resel,
    input logic [LINES-1:0] rpend,
    input logic [LINES-1:0] fpend,
    input logic [LINES-1:0] mask
);
    AST_SEL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < 4'd4) |-> ((bus_rdata & 32'hF8F8F8F8) == 32'h0)); // R2

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 4'd7) |=> ((rpend & $past(rpend)) == $past(rpend))); // R7

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd7) |=> ((rpend & $past(bus_wdata[LINES-1:0] & ~rise_set)) == '0)); // R7

    AST_RISE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_set) |=> ((rpend & $past(rise_set)) == $past(rise_set))); // R8

    AST_FALL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall_set) |=> ((fpend & $past(fall_set)) == $past(fall_set))); // R8

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (irq_req == 3'b000)); // R9

    AST_RESEL_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (|resel) |=> (((rise_det | fall_det) & $past(resel)) == '0)); // R10

endmodule

bind pin_edge_irq_ctrl pin_edge_irq_ctrl_chk #(.LINES(LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_req  (irq_req),
    .rise_det (rise_det),
    .fall_det (fall_det),
    .rise_set (rise_set),
    .fall_set (fall_set),
    .resel    (resel),
    .rpend    (rpend_q),
    .fpend    (fpend_q),
    .mask     (mask_q)
);

// File: tb/pin_edge_irq_ctrl_bench.sv
`timescale 1ns/1ps
module pin_edge_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] gpio_in = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pin_edge_irq_ctrl u_pin_edge_irq_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .gpio_in  (gpio_in),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_req  (irq_req)
    );

    typedef struct packed {
        logic [3:0] line;
        logic [2:0] sel;
        logic [2:0] drv;
        logic       rt;
        logic       ft;
        logic       im;
        logic       fall;
        logic       exp_rp;
        logic       exp_fp;
        logic [2:0] exp_irq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  3'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b001}, // R4 R9
        '{4'd1,  3'd1, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'b001}, // R5 R9
        '{4'd2,  3'd2, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'b010}, // R5
        '{4'd3,  3'd3, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'b010}, // R5
        '{4'd4,  3'd4, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b100}, // R4 R9
        '{4'd9,  3'd5, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000}, // R9 masked
        '{4'd12, 3'd2, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R6
        '{4'd13, 3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R5 wrong edge
        '{4'd15, 3'd4, 3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'b100}, // R5 R9
        '{4'd14, 3'd5, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R3
        '{4'd7,  3'd7, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R3
        '{4'd10, 3'd1, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b000}  // R5 wrong edge
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Called at a negedge; returns combinational read data.
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pin(input int port, input int line, input logic v);
        gpio_in[port*16 + line] = v;
    endtask

    task automatic prep_line(input int line, input int sel, input int port, input logic init);
        wr(4'd4, 32'h0); wr(4'd5, 32'h0); wr(4'd6, 32'h0);
        @(negedge clk);
        gpio_in = '0;
        if (init) pin(port, line, 1'b1);
        wr(4'(line / 4), 32'(sel) << ((line % 4) * 8));
        repeat (8) @(posedge clk);
        wr(4'd7, 32'hFFFF); wr(4'd8, 32'hFFFF);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), d);
            chk($sformatf("R1 reg %0d after reset", a), d, 32'h0);
        end
        chk("R1 irq after reset", {29'h0, irq_req}, 32'h0);
        rst_n = 1'b1;

        // R2 field layout and reserved bits
        wr(4'd1, 32'hFFFFFFFF);
        @(negedge clk); rd(4'd1, d);
        chk("R2 reserved bits read zero", d, 32'h07070707);
        wr(4'd3, 32'h05040302);
        @(negedge clk); rd(4'd3, d);
        chk("R2 field positions", d, 32'h05040302);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            prep_line(int'(v.line), int'(v.sel), int'(v.drv), v.fall);
            wr(4'd4, 32'(v.rt) << v.line);
            wr(4'd5, 32'(v.ft) << v.line);
            wr(4'd6, 32'(v.im) << v.line);
            pin(int'(v.drv), int'(v.line), ~v.fall);
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk($sformatf("R9 vec %0d irq", i), {29'h0, irq_req}, {29'h0, v.exp_irq});
            rd(4'd7, d);
            chk($sformatf("R4 vec %0d rising pending", i), d, 32'(v.exp_rp) << v.line);
            rd(4'd8, d);
            chk($sformatf("R5 vec %0d falling pending", i), d, 32'(v.exp_fp) << v.line);
        end

        // R4 latency: not visible after two edges, visible after three
        prep_line(2, 2, 2, 1'b0);
        wr(4'd4, 32'h4);
        pin(2, 2, 1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk); rd(4'd7, d);
        chk("R4 pending not before third edge", d, 32'h0);
        @(posedge clk);
        @(negedge clk); rd(4'd7, d);
        chk("R4 pending after third edge", d, 32'h4);

        // R5 both edges on one line
        prep_line(6, 3, 3, 1'b0);
        wr(4'd4, 32'h40); wr(4'd5, 32'h40);
        pin(3, 6, 1'b1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        pin(3, 6, 1'b0);
        repeat (5) @(posedge clk);
        @(negedge clk); rd(4'd7, d);
        chk("R5 both-edge rising flag", d, 32'h40);
        rd(4'd8, d);
        chk("R5 both-edge falling flag", d, 32'h40);

        // R7 write-1-to-clear
        prep_line(4, 0, 0, 1'b0);
        wr(4'd1, 32'h0);
        wr(4'd4, 32'h30);
        @(negedge clk);
        pin(0, 4, 1'b1); pin(0, 5, 1'b1);
        repeat (5) @(posedge clk);
        @(negedge clk); rd(4'd7, d);
        chk("R7 two flags set", d, 32'h30);
        wr(4'd7, 32'h0);
        @(negedge clk); rd(4'd7, d);
        chk("R7 writing zero keeps flags", d, 32'h30);
        wr(4'd7, 32'h10);
        @(negedge clk); rd(4'd7, d);
        chk("R7 writing one clears only that flag", d, 32'h20);

        // R8 collision of set and clear on line 4 rising flag
        wr(4'd7, 32'hFFFF);
        @(negedge clk); pin(0, 4, 1'b0);
        repeat (5) @(posedge clk);
        @(negedge clk); pin(0, 4, 1'b1);
        repeat (5) @(posedge clk);
        @(negedge clk); pin(0, 4, 1'b0);
        repeat (5) @(posedge clk);
        @(negedge clk); rd(4'd7, d);
        chk("R8 flag set before collision", d & 32'h10, 32'h10);
        pin(0, 4, 1'b1);
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd7; bus_wdata = 32'h10;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd(4'd7, d);
        chk("R8 set wins over same-cycle clear", d & 32'h10, 32'h10);
        wr(4'd7, 32'h10);
        @(negedge clk); rd(4'd7, d);
        chk("R8 later clear without edge", d & 32'h10, 32'h0);

        // R10 selection change with differing pin levels
        prep_line(0, 0, 0, 1'b0);
        pin(1, 0, 1'b1);
        wr(4'd4, 32'h1); wr(4'd5, 32'h1); wr(4'd6, 32'h1);
        wr(4'd0, 32'h1);
        repeat (8) @(posedge clk);
        @(negedge clk); rd(4'd7, d);
        chk("R10 no rising flag on reselect", d, 32'h0);
        rd(4'd8, d);
        chk("R10 no falling flag on reselect", d, 32'h0);
        chk("R10 no irq on reselect", {29'h0, irq_req}, 32'h0);
        pin(1, 0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk); rd(4'd8, d);
        chk("R10 detection resumes after reselect", d, 32'h1);
        chk("R6 old port pin ignored", {29'h0, irq_req}, 32'h1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule